// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator with Start-Up Holdoff

This block decides when a UART transmitter reports that its transmit holding register has gone empty. It watches the occupancy count of a 16-entry transmit FIFO, the strobe for writes into the holding register, and the strobe for reads of the interrupt identification register. From these it keeps one pending flag. When that flag is set, the block also presents the identification code for this source.

When the FIFO drains, the flag is raised at once only if the FIFO held at least two characters at the same time since the previous raise. Otherwise the block first waits one character time without the stop bit, counted in bit-time ticks. This holdoff gives software time to refill the FIFO after start-up, so that no interrupt has to be serviced. A write during the holdoff cancels it.

The flag is cleared by any holding-register write. It is also cleared by an identification read, but only while this source is the highest-priority one pending. Serialization and arbitration between interrupt sources belong to neighbouring blocks.

Top module: `thre_irq_gen`

## Requirements
- R1: Reset clears the pending flag. While the flag is set, `irq_id_o` reads 3'b001, the third priority level. Otherwise it reads 3'b000.
- R2: The pending flag rises only after a clock edge at which `fifo_cnt_i` was 0.
- R3: When the FIFO becomes empty and has not held two or more entries since the last raise, the flag rises on the Nth `bit_tick_i` edge after the edge at which the empty count was first seen. N is the holdoff length from R7.
- R4: When the FIFO becomes empty and `fifo_cnt_i` has been 2 or more at some edge since the last raise, the flag rises on the edge at which the empty count is first seen.
- R5: A `thr_wr_i` pulse clears the pending flag at the next edge. A raise that would happen on that same edge is suppressed.
- R6: An `iir_rd_i` pulse clears the flag only when `thre_top_i` is high. With `thre_top_i` low, the read leaves the flag unchanged.
- R7: The holdoff length in bit ticks is 1 + (5 + `data_sel_i`) + `parity_en_i`. `data_sel_i` encodes 0→5, 1→6, 2→7 and 3→8 data bits. The length is captured when the holdoff starts, and stop bits are not counted.
- R8: A write during the holdoff cancels it, and no raise follows. A new holdoff starts only after the FIFO has been non-empty and empty again.
- R9: Every raise clears the record that the FIFO held two or more entries, so the next empty period that follows a single-entry fill uses the holdoff.
- R10: Each empty period gives at most one raise. After a raise or a cancel, no new raise occurs until `fifo_cnt_i` has been non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_cnt_i | input | 5 | TX FIFO occupancy (0..16) |
| thr_wr_i | input | 1 | Write strobe into the holding register |
| iir_rd_i | input | 1 | Identification register read strobe |
| thre_top_i | input | 1 | This source is the highest pending one |
| bit_tick_i | input | 1 | One pulse per transmit bit time |
| data_sel_i | input | 2 | Data bits per character, minus 5 |
| parity_en_i | input | 1 | Frame carries a parity bit |
| thre_pend_o | output | 1 | Transmit-empty interrupt pending |
| irq_id_o | output | 3 | Identification code, 3'b001 when pending |

## Verification
The assertions assume that the occupancy count never exceeds the FIFO depth. They also assume that the count only goes up in the cycle after a write, so a pending flag cannot be overtaken by a non-empty FIFO that no write caused. The random stimulus keeps the count in a bench variable. That variable grows only after a driven write, shrinks only through modelled serializer pops, and never goes above 16. Identification reads and the top-priority indication are driven freely, since the clear rules must hold for every combination of the two.

// File: rtl/thre_pkg.sv
package thre_pkg;
  typedef enum logic [1:0] {
    ST_BUSY = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2
  } thre_state_e;

  localparam logic [2:0] THRE_ID = 3'b001;
  localparam logic [2:0] NONE_ID = 3'b000;
endpackage

// File: rtl/thre_frame_len.sv
module thre_frame_len #(
  parameter int MIN_DATA_BITS = 5,
  parameter bit HAS_PARITY    = 1'b1,
  parameter int LEN_W         = 4
) (
  input  logic [1:0]       data_sel_i,
  input  logic             parity_en_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] par_bits;

  generate
    if (HAS_PARITY) begin : g_par
      assign par_bits = LEN_W'(parity_en_i);
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = parity_en_i;
      assign par_bits   = '0;
    end
  endgenerate

  // start bit + data bits + parity; stop bits excluded
  assign len_o = LEN_W'(1 + MIN_DATA_BITS) + LEN_W'(data_sel_i) + par_bits;
endmodule

// File: rtl/thre_holdoff_timer.sv
module thre_holdoff_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (load_i)                        cnt_q <= len_i;
    else if (run_i && tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && tick_i && (cnt_q == LEN_W'(1));
endmodule

// File: rtl/thre_multi_track.sv
module thre_multi_track #(
  parameter int CNT_W       = 5,
  parameter int MULTI_LEVEL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             clr_i,
  output logic             multi_o
);
  logic multi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) multi_q <= 1'b0;
    else         multi_q <= (fifo_cnt_i >= CNT_W'(MULTI_LEVEL)) || (multi_q && !clr_i);
  end

  assign multi_o = multi_q;
endmodule

// File: rtl/thre_pending_flag.sv
module thre_pending_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic rd_clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= set_i || (pend_q && !wr_clr_i && !rd_clr_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
  import thre_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int MIN_DATA_BITS = 5,
  parameter int MULTI_LEVEL   = 2,
  parameter bit HAS_PARITY    = 1'b1,
  localparam int CNT_W        = $clog2(FIFO_DEPTH + 1),
  localparam int LEN_W        = $clog2(MIN_DATA_BITS + 6)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             thre_top_i,
  input  logic             bit_tick_i,
  input  logic [1:0]       data_sel_i,
  input  logic             parity_en_i,
  output logic             thre_pend_o,
  output logic [2:0]       irq_id_o
);
  thre_state_e      state_q, state_d;
  logic             fifo_empty;
  logic             multi_seen;
  logic             load_hold;
  logic             raise;
  logic             expire;
  logic [LEN_W-1:0] hold_len;

  assign fifo_empty = (fifo_cnt_i == '0);

  thre_frame_len #(
    .MIN_DATA_BITS(MIN_DATA_BITS),
    .HAS_PARITY   (HAS_PARITY),
    .LEN_W        (LEN_W)
  ) i_frame_len (
    .data_sel_i (data_sel_i),
    .parity_en_i(parity_en_i),
    .len_o      (hold_len)
  );

  thre_holdoff_timer #(.LEN_W(LEN_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_hold),
    .len_i   (hold_len),
    .run_i   (state_q == ST_HOLD),
    .tick_i  (bit_tick_i),
    .expire_o(expire)
  );

  thre_multi_track #(
    .CNT_W      (CNT_W),
    .MULTI_LEVEL(MULTI_LEVEL)
  ) i_multi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_cnt_i(fifo_cnt_i),
    .clr_i     (raise),
    .multi_o   (multi_seen)
  );

  always_comb begin
    state_d   = state_q;
    load_hold = 1'b0;
    raise     = 1'b0;
    unique case (state_q)
      ST_BUSY: if (fifo_empty) begin
        if (thr_wr_i)        state_d = ST_DONE;
        else if (multi_seen) begin raise = 1'b1; state_d = ST_DONE; end
        else                 begin load_hold = 1'b1; state_d = ST_HOLD; end
      end
      ST_HOLD: begin
        if (!fifo_empty)   state_d = ST_BUSY;
        else if (thr_wr_i) state_d = ST_DONE;  // cancel
        else if (expire)   begin raise = 1'b1; state_d = ST_DONE; end
      end
      ST_DONE: if (!fifo_empty) state_d = ST_BUSY;
      default: state_d = ST_BUSY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_BUSY;
    else         state_q <= state_d;
  end

  thre_pending_flag i_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (raise),
    .wr_clr_i(thr_wr_i),
    .rd_clr_i(iir_rd_i && thre_top_i),
    .pend_o  (thre_pend_o)
  );

  assign irq_id_o = thre_pend_o ? THRE_ID : NONE_ID;
endmodule

// File: rtl/thre_irq_checker.sv
module thre_irq_checker #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             thr_wr_i,
  input logic             iir_rd_i,
  input logic             thre_top_i,
  input logic             thre_pend_o
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CNT_W'(FIFO_DEPTH));
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !thre_pend_o); // R5
  AST_TOP_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && thre_top_i && thre_pend_o) |=> !thre_pend_o); // R6
  AST_OTHER_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && !thre_top_i && !thr_wr_i && thre_pend_o) |=> thre_pend_o); // R6
  AST_RAISE_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thre_pend_o) |-> ($past(fifo_cnt_i) == '0)); // R2
endmodule

bind thre_irq_gen thre_irq_checker #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .CNT_W     (CNT_W)
) i_thre_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_cnt_i (fifo_cnt_i),
  .thr_wr_i   (thr_wr_i),
  .iir_rd_i   (iir_rd_i),
  .thre_top_i (thre_top_i),
  .thre_pend_o(thre_pend_o)
);

// File: tb/test_thre_irq_gen.sv
`timescale 1ns/1ps
module test_thre_irq_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] fifo_cnt_i = '0;
  logic       thr_wr_i = 1'b0;
  logic       iir_rd_i = 1'b0;
  logic       thre_top_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic [1:0] data_sel_i = 2'd3;
  logic       parity_en_i = 1'b0;
  logic       thre_pend_o;
  logic [2:0] irq_id_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  thre_irq_gen i_thre_irq_gen (.*);

  // reference model, written from the requirements
  int m_state, m_cnt;
  bit m_multi, m_pend;

  function automatic int hold_len(input int sel, input bit par);
    return 1 + 5 + sel + int'(par);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_multi = 0; m_pend = 0;
    end else begin
      bit emp, rs, exp_t;
      int ns, nc;
      emp = (fifo_cnt_i == 0);
      rs = 0; ns = m_state; nc = m_cnt;
      exp_t = (m_state == 1) && bit_tick_i && (m_cnt == 1);
      if (m_state == 1 && bit_tick_i && m_cnt != 0) nc = m_cnt - 1;
      case (m_state)
        0: if (emp) begin
             if (thr_wr_i) ns = 2;
             else if (m_multi) begin rs = 1; ns = 2; end
             else begin ns = 1; nc = hold_len(data_sel_i, parity_en_i); end
           end
        1: if (!emp) ns = 0;
           else if (thr_wr_i) ns = 2;
           else if (exp_t) begin rs = 1; ns = 2; end
        default: if (!emp) ns = 0;
      endcase
      m_multi = (fifo_cnt_i >= 2) || (m_multi && !rs);
      m_pend  = rs || (m_pend && !thr_wr_i && !(iir_rd_i && thre_top_i));
      m_state = ns; m_cnt = nc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pend(input string req, input bit exp);
    check(thre_pend_o == exp, req, int'(thre_pend_o), int'(exp));
  endtask

  task automatic cyc(input bit wr, input int cnt, input bit tk, input bit rd, input bit top);
    thr_wr_i = wr; fifo_cnt_i = 5'(cnt); bit_tick_i = tk;
    iir_rd_i = rd; thre_top_i = top;
    @(posedge clk_i); #5;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0);
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk_i); #5;
    chk_pend("R1 reset", 0);
    check(irq_id_o == 3'b000, "R1 id idle", int'(irq_id_o), 0);
    rst_ni = 1'b1;
    // start-up holdoff, 8 data bits, no parity -> 9 ticks
    cyc(0, 0, 0, 0, 0);
    ticks(8);
    chk_pend("R3 before holdoff end", 0);
    ticks(1);
    chk_pend("R3 at holdoff end", 1);
    check(irq_id_o == 3'b001, "R1 id pending", int'(irq_id_o), 1);
    cyc(0, 0, 0, 1, 0);
    chk_pend("R6 read not top", 1);
    cyc(0, 0, 0, 1, 1);
    chk_pend("R6 read top", 0);
    ticks(12);
    chk_pend("R10 single raise", 0);
    // immediate raise after two entries
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 2, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    chk_pend("R4 not yet empty", 0);
    cyc(0, 0, 0, 0, 0);
    chk_pend("R4 immediate", 1);
    cyc(1, 0, 0, 0, 0);
    chk_pend("R5 write clears", 0);
    // single entry after a raise: holdoff again, 5 bits + parity -> 7
    data_sel_i = 2'd0; parity_en_i = 1'b1;
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk_pend("R9 multi cleared", 0);
    ticks(6);
    chk_pend("R7 len 7 minus one", 0);
    ticks(1);
    chk_pend("R7 len 7", 1);
    // cancel during holdoff
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    ticks(3);
    cyc(1, 0, 1, 0, 0);
    chk_pend("R8 cancel", 0);
    ticks(10);
    chk_pend("R8 no raise after cancel", 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    ticks(7);
    chk_pend("R8 rearmed", 1);
    // write on the edge that would raise immediately
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 2, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk_pend("R5 raise suppressed", 0);

    // random phase against the model
    void'($urandom(32'd1234));
    cnt = 1;
    for (int c = 0; c < 20000; c++) begin
      bit wr, pop;
      if (c % 997 == 0) begin
        data_sel_i  = 2'($urandom % 4);
        parity_en_i = 1'($urandom % 2);
      end
      wr  = (cnt < 16) && ($urandom % 9 == 0);
      pop = (cnt > 0) && ($urandom % 5 == 0);
      cyc(wr, cnt, ($urandom % 3 == 0), ($urandom % 6 == 0), 1'($urandom % 2));
      cnt = cnt + int'(wr) - int'(pop);
      check(thre_pend_o == m_pend, "R2/R3/R4/R5/R6/R8/R10 random pend",
            int'(thre_pend_o), int'(m_pend));
      check(irq_id_o == (m_pend ? 3'b001 : 3'b000), "R1 random id",
            int'(irq_id_o), m_pend ? 1 : 0);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule